// File: doc/BRIEF.md
# Banked DRAM Strobe Steering

This block routes three active-low DRAM strobe requests to the memory array. The requests are a row strobe, a column strobe and a write request. It drives four row-strobe lines, one column-strobe line and one write-enable line, all active low. A chip-select input gates normal accesses. A bank-select input picks which row-strobe line or lines follow the row-strobe request. A row/column select input marks whether column addresses are currently on the address bus. The column strobe is passed through only when they are.

A refresh request overrides bank decoding. While a refresh is honoured, every row-strobe line follows the row-strobe request together, and the column strobe and write enable are held inactive. A build-time parameter chooses between two variants. In the four-bank variant one bank is enabled per access, and a refresh may overlap an access that has chip select active. In the paired-bank variant one select bit enables two row-strobe lines at a time, halving the load on each line. That variant does not support overlapped refresh: a refresh request arriving while chip select is active is ignored, and the access proceeds.

Every output is registered. Each output reflects the inputs sampled at the previous rising clock edge.

Top module: `strobe_steer`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, all six outputs are high after that edge.
- R2: In the four-bank variant (PAIRED=0) during an access (refresh low, `cs_n` low), only `ras_n[bank_sel]` follows `ras_in_n`, and the other three row-strobe lines are high.
- R3: In the paired-bank variant (PAIRED=1) during an access, `bank_sel[1]`=0 makes `ras_n[0]` and `ras_n[1]` follow `ras_in_n`, and `bank_sel[1]`=1 does the same for `ras_n[2]` and `ras_n[3]`. The other pair is high, and `bank_sel[0]` has no effect.
- R4: `cas_n` is high whenever `rowsel` was high (row address selected). During an access with `rowsel` low (column address selected), `cas_n` follows `cas_in_n`.
- R5: During an access, `we_n` follows `wr_in_n`.
- R6: With `refresh` low and `cs_n` high, all row-strobe lines, `cas_n` and `we_n` are high.
- R7: When a refresh is honoured, all four `ras_n` lines equal `ras_in_n`, regardless of `bank_sel`, and `cas_n` and `we_n` are high.
- R8: In the four-bank variant, `refresh` high is honoured even with `cs_n` low, and it takes precedence over the access.
- R9: In the paired-bank variant, `refresh` high with `cs_n` low is ignored, and the outputs follow the access rules of R3 to R5. With `cs_n` high, the refresh is honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_in_n | input | 1 | Row-strobe request, active low |
| cas_in_n | input | 1 | Column-strobe request, active low |
| wr_in_n | input | 1 | Write request, active low |
| rowsel | input | 1 | 1 = row address selected, 0 = column address selected |
| cs_n | input | 1 | Chip select, active low |
| refresh | input | 1 | Refresh request, active high |
| bank_sel | input | 2 | Bank select |
| ras_n | output | 4 | Row-strobe lines, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
A wrong internal mode or bank decode shows at the ports one clock after the inputs that provoke it. It appears either as a second row-strobe line falling alongside the selected one, or as a line that stays high when it should follow the request. A mistaken refresh/access precedence shows as the column strobe or write enable moving during a refresh, or as every row line falling during a plain access. Both variants run side by side on the same stimulus. Every output is compared against a behavioural model on every cycle, so any such error is caught on the cycle it first appears.

// File: rtl/strobe_steer_pkg.sv
// Package: shared types for the strobe steering block.
// Assumes: nothing beyond IEEE 1800-2017.
package strobe_steer_pkg;
    // Operating state chosen each cycle
    typedef enum logic [1:0] {
        SS_IDLE    = 2'd0,
        SS_ACCESS  = 2'd1,
        SS_REFRESH = 2'd2
    } steer_mode_e;
endpackage

// File: rtl/steer_mode_sel.sv
// Module: picks idle, access or refresh from chip select and refresh request.
// Assumes: PAIRED=1 forbids refresh overlapping an access (access wins);
//          PAIRED=0 lets refresh preempt an access.
module steer_mode_sel
    import strobe_steer_pkg::*;
#(
    parameter bit PAIRED = 1'b0
) (
    input  logic        cs_n,
    input  logic        refresh,
    output steer_mode_e mode
);
    // Resolve precedence between refresh and access
    always_comb begin
        if (refresh && (cs_n || !PAIRED)) begin
            mode = SS_REFRESH;
        end else if (!cs_n) begin
            mode = SS_ACCESS;
        end else begin
            mode = SS_IDLE;
        end
    end
endmodule

// File: rtl/steer_bank_decode.sv
// Module: turns the bank select into a per-line enable mask.
// Assumes: NUM_RAS is even; in paired form the top select bit picks a half.
module steer_bank_decode #(
    parameter int NUM_RAS = 4,
    parameter bit PAIRED  = 1'b0,
    localparam int SEL_W  = $clog2(NUM_RAS),
    localparam int HALF   = NUM_RAS / 2
) (
    input  logic [SEL_W-1:0]   bank_sel,
    output logic [NUM_RAS-1:0] enable
);
    generate
        if (PAIRED) begin : g_pair
            // Enable the half addressed by the top select bit
            always_comb begin
                for (int i = 0; i < NUM_RAS; i++) begin
                    enable[i] = ((i / HALF) == int'(bank_sel[SEL_W-1]));
                end
            end
        end else begin : g_single
            // Enable exactly the addressed line
            always_comb begin
                for (int i = 0; i < NUM_RAS; i++) begin
                    enable[i] = (i == int'(bank_sel));
                end
            end
        end
    endgenerate
endmodule

// File: rtl/strobe_steer.sv
// Module: registered steering of row/column/write strobes to a banked array.
// Assumes: all strobes active low; outputs lag inputs by one clock;
//          synchronous active-low reset drives every strobe inactive.
module strobe_steer
    import strobe_steer_pkg::*;
#(
    parameter int NUM_RAS = 4,
    parameter bit PAIRED  = 1'b0,
    localparam int SEL_W  = $clog2(NUM_RAS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ras_in_n,
    input  logic               cas_in_n,
    input  logic               wr_in_n,
    input  logic               rowsel,
    input  logic               cs_n,
    input  logic               refresh,
    input  logic [SEL_W-1:0]   bank_sel,
    output logic [NUM_RAS-1:0] ras_n,
    output logic               cas_n,
    output logic               we_n
);
    steer_mode_e        mode;
    logic [NUM_RAS-1:0] bank_en;
    logic [NUM_RAS-1:0] ras_nx;
    logic               cas_nx;
    logic               we_nx;

    steer_mode_sel #(.PAIRED(PAIRED)) u_mode (
        .cs_n    (cs_n),
        .refresh (refresh),
        .mode    (mode)
    );

    steer_bank_decode #(.NUM_RAS(NUM_RAS), .PAIRED(PAIRED)) u_dec (
        .bank_sel (bank_sel),
        .enable   (bank_en)
    );

    // Next strobe levels for the current mode
    always_comb begin
        ras_nx = '1;
        cas_nx = 1'b1;
        we_nx  = 1'b1;
        unique case (mode)
            SS_REFRESH: ras_nx = {NUM_RAS{ras_in_n}};
            SS_ACCESS: begin
                ras_nx = ~(bank_en & {NUM_RAS{~ras_in_n}});
                cas_nx = rowsel | cas_in_n;
                we_nx  = wr_in_n;
            end
            default: ;
        endcase
    end

    // Register outputs; reset parks all strobes inactive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_n <= '1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
        end else begin
            ras_n <= ras_nx;
            cas_n <= cas_nx;
            we_n  <= we_nx;
        end
    end

    // ---------------- assertions ----------------
    logic past_ok;
    // Marks that one edge has passed so $past is meaningful
    always_ff @(posedge clk) past_ok <= 1'b1;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        (past_ok === 1'b1) && !$past(rst_n) |-> (&ras_n && cas_n && we_n));

    // R4
    row_blocks_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok === 1'b1) && $past(rst_n) && $past(rowsel) |-> cas_n);

    // R6
    deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok === 1'b1) && $past(rst_n) && $past(!refresh && cs_n)
        |-> (&ras_n && cas_n && we_n));

    // R7
    refresh_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok === 1'b1) && $past(rst_n) && $past(refresh && (cs_n || !PAIRED))
        |-> (ras_n == {NUM_RAS{$past(ras_in_n)}} && cas_n && we_n));

    // R2
    single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok === 1'b1) && !PAIRED && $past(rst_n) && $past(!refresh)
        |-> $onehot0(~ras_n));

    // R3
    pair_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok === 1'b1) && PAIRED && $past(rst_n) && $past(!refresh || !cs_n)
        |-> ($countones(~ras_n) == 0 || $countones(~ras_n) == 2));
endmodule

// File: tb/strobe_steer_test.sv
module strobe_steer_test;
    logic       clk = 1'b0;
    logic       rst_n, ras_in_n, cas_in_n, wr_in_n, rowsel, cs_n, refresh;
    logic [1:0] bank_sel;
    logic [3:0] ras4, ras2;
    logic       cas4, cas2, we4, we2;
    int         n_cmp = 0, n_bad = 0;
    bit         have_exp = 1'b0, done = 1'b0;
    logic [5:0] exp4, exp2;
    string      tag4, tag2;

    always #10 clk = ~clk;

    strobe_steer #(.PAIRED(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .ras_in_n(ras_in_n), .cas_in_n(cas_in_n),
        .wr_in_n(wr_in_n), .rowsel(rowsel), .cs_n(cs_n), .refresh(refresh),
        .bank_sel(bank_sel), .ras_n(ras4), .cas_n(cas4), .we_n(we4));

    strobe_steer #(.PAIRED(1'b1)) uut_pair (
        .clk(clk), .rst_n(rst_n), .ras_in_n(ras_in_n), .cas_in_n(cas_in_n),
        .wr_in_n(wr_in_n), .rowsel(rowsel), .cs_n(cs_n), .refresh(refresh),
        .bank_sel(bank_sel), .ras_n(ras2), .cas_n(cas2), .we_n(we2));

    // Behavioural expectation: {ras[3:0], cas, we}
    function automatic logic [5:0] model(bit pair);
        logic [3:0] r = 4'b1111;
        if (!rst_n) return 6'b111111;
        if (refresh && (cs_n || !pair)) return {{4{ras_in_n}}, 2'b11};
        if (cs_n) return 6'b111111;
        for (int i = 0; i < 4; i++) begin
            bit on = pair ? ((i >= 2) == bank_sel[1]) : (i == bank_sel);
            if (on) r[i] = ras_in_n;
        end
        return {r, (rowsel ? 1'b1 : cas_in_n), wr_in_n};
    endfunction

    function automatic string req_of(bit pair);
        if (!rst_n) return "R1";
        if (refresh && !cs_n) return pair ? "R9" : "R8";
        if (refresh) return "R7";
        if (cs_n) return "R6";
        return pair ? "R3/R4/R5" : "R2/R4/R5";
    endfunction

    task automatic cmp(string nm, string tag, logic [5:0] act, logic [5:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b (ras,cas,we)", tag, nm, act, exp);
        end
    endtask

    // Compare last cycle's expectation, then apply new inputs
    task automatic step(logic rs, logic rf, logic cs, logic rw, logic [1:0] bk,
                        logic ra, logic ca, logic wr);
        @(negedge clk);
        if (have_exp) begin
            cmp("four-bank", tag4, {ras4, cas4, we4}, exp4);
            cmp("paired",    tag2, {ras2, cas2, we2}, exp2);
        end
        rst_n = rs; refresh = rf; cs_n = cs; rowsel = rw; bank_sel = bk;
        ras_in_n = ra; cas_in_n = ca; wr_in_n = wr;
        exp4 = model(1'b0); tag4 = req_of(1'b0);
        exp2 = model(1'b1); tag2 = req_of(1'b1);
        have_exp = 1'b1;
    endtask

    initial begin
        // R1: reset with all requests active still yields idle strobes
        step(0, 1, 0, 0, 2'd2, 0, 0, 0);
        step(0, 0, 0, 0, 2'd1, 0, 0, 0);
        // R2/R3: walk every bank with row strobe low, row address selected (R4)
        for (int b = 0; b < 4; b++) begin
            step(1, 0, 0, 1, 2'(b), 0, 0, 1);
            // R4/R5: column phase, write low
            step(1, 0, 0, 0, 2'(b), 0, 0, 0);
            step(1, 0, 0, 0, 2'(b), 1, 1, 1);
        end
        // R6: deselected, all requests low
        step(1, 0, 1, 0, 2'd3, 0, 0, 0);
        // R7: refresh while deselected, both variants honour it
        step(1, 1, 1, 0, 2'd0, 0, 0, 0);
        step(1, 1, 1, 0, 2'd3, 1, 0, 0);
        // R8/R9: refresh overlapping an active access
        step(1, 1, 0, 0, 2'd1, 0, 0, 0);
        step(1, 1, 0, 0, 2'd2, 0, 0, 1);
        // Random mix
        for (int k = 0; k < 400; k++) begin
            logic [7:0] v = 8'($urandom);
            step(k % 97 != 5, v[0] & v[1], v[2] & ~v[3], v[4], v[6:5], v[7],
                 $urandom % 2 == 0, $urandom % 2 == 0);
        end
        step(1, 0, 1, 1, 2'd0, 1, 1, 1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule